// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block decides, once per downstream switching period, whether a two-stage supply runs normally or in a power-saving burst regime. It reads two digitized feedback values: the downstream duty command, which tracks delivered power, and the scaled front-end bus voltage. From these it drives three outputs. The first enables the front-end (boost) stage. The second permits or withholds the downstream pulse of the current period. The third flags light-load operation. A debug output reports the command threshold that the next decision will use.

All decisions are taken on the cycle where the period-start strobe is high. Nothing changes between strobes. In normal operation the front end runs and every period is permitted. A low command moves the block into light-load operation. Once the bus has been charged high, the front end stops and pulses are issued only when the command climbs to an upper threshold, so the downstream stage skips pulses in step with its master clock. When the bus sags below a recharge level, the front end restarts and the light-load decision is taken again from scratch. Light-load operation is therefore only left at, or during, a recharge.

Top module: `lightload_burst_ctrl`

## Requirements
- R1: After reset, fe_en_o=1, light_mode_o=0, pulse_permit_o=1 and thr_o=CMD_LO.
- R2: With the front end running and a command at or above CMD_LO on a strobe, light_mode_o stays or becomes 0, fe_en_o stays 1 and pulse_permit_o is 1 after that strobe. The boundary cmd=CMD_LO counts as normal.
- R3: With the front end running, a strobe whose command is below CMD_LO sets light_mode_o from the following cycle.
- R4: With the front end running, a strobe with cmd<CMD_LO and bus>=BUS_HI clears fe_en_o and switches thr_o to CMD_HI.
- R5: With the front end off, a strobe sets pulse_permit_o to 1 when cmd>=CMD_HI and to 0 when cmd<CMD_HI. The boundary cmd=CMD_HI is permitted.
- R6: With the front end off, a strobe with bus<BUS_LO sets fe_en_o. A strobe with bus=BUS_LO leaves it off.
- R7: While the front end is off, light_mode_o stays 1 whatever the command. On the strobe that restarts the front end, light_mode_o becomes 1 if cmd<CMD_LO and 0 otherwise.
- R8: On every strobe taken while the front end is running (recharge included), pulse_permit_o becomes 1 whatever the command, and thr_o equals CMD_LO.
- R9: Without a strobe, changes on cmd_sample_i and bus_sample_i leave all outputs unchanged.
- R10: During a light-load recharge with cmd<CMD_LO, fe_en_o stays 1 while bus<BUS_HI. This holds at bus=BUS_HI-1.
- R11: A recharge strobe with cmd>=CMD_LO returns the block to normal mode. The front end then keeps running on later strobes, even with bus>=BUS_HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_start_i | input | 1 | One-cycle strobe at the start of each downstream period |
| cmd_sample_i | input | W | Downstream duty-command sample |
| bus_sample_i | input | W | Scaled front-end bus voltage sample |
| fe_en_o | output | 1 | Front-end stage enable |
| pulse_permit_o | output | 1 | Downstream pulse allowed in the current period |
| light_mode_o | output | 1 | Light-load mode flag |
| thr_o | output | W | Command threshold to be applied at the next strobe |

## Verification
The bench probes each threshold exactly at its edge. The points are cmd equal to CMD_LO and CMD_HI, bus equal to BUS_LO, and bus at BUS_HI-1 and at BUS_HI. A design with a strict comparison where an inclusive one is needed, or the reverse, flips a pulse or a front-end decision at one of these points. The bench also sends a command above both thresholds while the front end is off. A design that lets light-load mode be left outside a recharge drops the flag there, and one that restarts the front end with the mode still latched misses the re-decision at turn-on. It checks that pulses run continuously during recharge even with a low command, which a design that always gates on the upper threshold would suppress. Finally it moves the samples between strobes to catch any decision taken off the strobe.

// File: rtl/lightload_pkg.sv
package lightload_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,  // front end on, normal
    ST_RUN_LL = 2'd1,  // front end on, light load (charging toward high)
    ST_SKIP   = 2'd2   // front end off, pulse skipping
  } ll_state_e;

  typedef struct packed {
    logic cmd_lt_lo;
    logic cmd_lt_hi;
    logic bus_lt_lo;
    logic bus_lt_hi;
  } ll_flags_t;

  localparam int unsigned NUM_CMP = 2;

endpackage

// File: rtl/llb_lt_cmp.sv
module llb_lt_cmp #(
  parameter int unsigned W   = 10,
  parameter int unsigned THR = 0
) (
  input  logic [W-1:0] val_i,
  output logic         lt_o
);
  localparam logic [W-1:0] THR_W = W'(THR);

  assign lt_o = (val_i < THR_W);
endmodule

// File: rtl/llb_mode_fsm.sv
module llb_mode_fsm
  import lightload_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      strobe_i,
  input  ll_flags_t flags_i,
  output logic      fe_on_o,
  output logic      light_o
);
  ll_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN, ST_RUN_LL: begin
        if (flags_i.cmd_lt_lo) state_d = flags_i.bus_lt_hi ? ST_RUN_LL : ST_SKIP;
        else                   state_d = ST_RUN;
      end
      ST_SKIP: begin
        // mode is re-decided each time the front end restarts
        if (flags_i.bus_lt_lo) state_d = flags_i.cmd_lt_lo ? ST_RUN_LL : ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_RUN;
    else if (strobe_i) state_q <= state_d;
  end

  assign fe_on_o = (state_q != ST_SKIP);
  assign light_o = (state_q != ST_RUN);

  a_r4_off_needs_full_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fe_on_o) |-> $past(flags_i.cmd_lt_lo && !flags_i.bus_lt_hi));

  a_r6_on_needs_low_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_on_o) |-> $past(flags_i.bus_lt_lo));

  a_r7_exit_in_recharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(light_o) |-> ($rose(fe_on_o) || $past(fe_on_o)));

  a_r7_off_means_light: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fe_on_o |-> light_o);

  a_r9_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(fe_on_o) && $stable(light_o)));
endmodule

// File: rtl/llb_pulse_gate.sv
module llb_pulse_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic fe_on_i,
  input  logic cmd_lt_hi_i,
  output logic permit_o
);
  logic permit_d;

  // running front end: continuous pulses; otherwise gate on upper threshold
  assign permit_d = fe_on_i | ~cmd_lt_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       permit_o <= 1'b1;
    else if (strobe_i) permit_o <= permit_d;
  end

  a_r8_run_permits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && fe_on_i) |=> permit_o);

  a_r5_skip_below_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !fe_on_i && cmd_lt_hi_i) |=> !permit_o);
endmodule

// File: rtl/lightload_burst_ctrl.sv
module lightload_burst_ctrl
  import lightload_pkg::*;
#(
  parameter int unsigned W      = 10,
  parameter int unsigned CMD_LO = 266,
  parameter int unsigned CMD_HI = 323,
  parameter int unsigned BUS_LO = 461,
  parameter int unsigned BUS_HI = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         period_start_i,
  input  logic [W-1:0] cmd_sample_i,
  input  logic [W-1:0] bus_sample_i,
  output logic         fe_en_o,
  output logic         pulse_permit_o,
  output logic         light_mode_o,
  output logic [W-1:0] thr_o
);
  localparam logic [W-1:0] CMD_LO_W = W'(CMD_LO);
  localparam logic [W-1:0] CMD_HI_W = W'(CMD_HI);

  ll_flags_t            flags;
  logic [NUM_CMP-1:0]   cmd_lt, bus_lt;
  logic                 fe_on;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    llb_lt_cmp #(.W(W), .THR(i == 0 ? CMD_LO : CMD_HI)) u_cmd (
      .val_i(cmd_sample_i), .lt_o(cmd_lt[i]));
    llb_lt_cmp #(.W(W), .THR(i == 0 ? BUS_LO : BUS_HI)) u_bus (
      .val_i(bus_sample_i), .lt_o(bus_lt[i]));
  end

  assign flags.cmd_lt_lo = cmd_lt[0];
  assign flags.cmd_lt_hi = cmd_lt[1];
  assign flags.bus_lt_lo = bus_lt[0];
  assign flags.bus_lt_hi = bus_lt[1];

  llb_mode_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (period_start_i),
    .flags_i  (flags),
    .fe_on_o  (fe_on),
    .light_o  (light_mode_o)
  );

  llb_pulse_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (period_start_i),
    .fe_on_i     (fe_on),
    .cmd_lt_hi_i (flags.cmd_lt_hi),
    .permit_o    (pulse_permit_o)
  );

  assign fe_en_o = fe_on;
  assign thr_o   = fe_on ? CMD_LO_W : CMD_HI_W;

  initial begin
    a_thr_order: assert (CMD_LO < CMD_HI && BUS_LO < BUS_HI && BUS_HI < (1 << W));
  end

  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (fe_en_o && !light_mode_o));

  a_r8_thr_low_when_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_i && fe_en_o && pulse_permit_o) |-> (thr_o < CMD_HI_W));
endmodule

// File: tb/lightload_burst_ctrl_tb.sv
module lightload_burst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 10;
  localparam int CMD_LO = 266;
  localparam int CMD_HI = 323;
  localparam int BUS_LO = 461;
  localparam int BUS_HI = 512;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         strobe = 1'b0;
  logic [W-1:0] cmd = '0;
  logic [W-1:0] bus = '0;
  logic         fe_en, permit, light;
  logic [W-1:0] thr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lightload_burst_ctrl #(
    .W(W), .CMD_LO(CMD_LO), .CMD_HI(CMD_HI), .BUS_LO(BUS_LO), .BUS_HI(BUS_HI)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .period_start_i(strobe),
    .cmd_sample_i(cmd), .bus_sample_i(bus),
    .fe_en_o(fe_en), .pulse_permit_o(permit), .light_mode_o(light), .thr_o(thr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int e_fe, input int e_pm,
                         input int e_lt, input int e_thr);
    chk({req, " fe_en"},  int'(fe_en),  e_fe);
    chk({req, " permit"}, int'(permit), e_pm);
    chk({req, " light"},  int'(light),  e_lt);
    chk({req, " thr"},    int'(thr),    e_thr);
  endtask

  // one period-start strobe; outputs sampled at the following falling edge
  task automatic period(input int c, input int b);
    @(negedge clk);
    cmd = W'(c); bus = W'(b); strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic t_reset;
    chk_all("R1", 1, 1, 0, CMD_LO);
  endtask

  task automatic t_normal;
    period(500, 300);
    chk_all("R2", 1, 1, 0, CMD_LO);
    period(CMD_LO, BUS_HI + 20);
    chk_all("R2 boundary", 1, 1, 0, CMD_LO);
  endtask

  task automatic t_entry;
    period(CMD_LO - 1, BUS_HI - 1);
    chk_all("R3", 1, 1, 1, CMD_LO);     // R10: bus one below high keeps front end on
    period(100, BUS_HI);
    chk_all("R4", 0, 1, 1, CMD_HI);
  endtask

  task automatic t_skip;
    period(CMD_HI - 1, BUS_HI);
    chk_all("R5 skip", 0, 0, 1, CMD_HI);
    period(CMD_HI, BUS_HI);
    chk_all("R5 boundary", 0, 1, 1, CMD_HI);
    period(1000, BUS_LO);
    chk_all("R6 R7 hold", 0, 1, 1, CMD_HI);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    cmd = '0; bus = '0;
    repeat (5) @(negedge clk);
    cmd = W'(1000);
    repeat (3) @(negedge clk);
    chk_all("R9", 0, 1, 1, CMD_HI);
  endtask

  task automatic t_recharge;
    period(CMD_HI - 1, BUS_LO - 1);     // turn-on with cmd above low: mode clears
    chk_all("R6 R7 exit", 1, 0, 0, CMD_LO);
    period(CMD_LO - 1, 470);
    chk_all("R8 R3", 1, 1, 1, CMD_LO);
    period(10, BUS_HI - 1);
    chk_all("R10 R8", 1, 1, 1, CMD_LO);
    period(100, BUS_HI);
    chk_all("R4 again", 0, 1, 1, CMD_HI);
    period(50, 0);                      // turn-on with cmd still low: mode stays
    chk_all("R7 reenter", 1, 0, 1, CMD_LO);
    period(50, 0);
    chk_all("R8 continuous", 1, 1, 1, CMD_LO);
  endtask

  task automatic t_exit;
    period(600, BUS_HI + 10);
    chk_all("R11", 1, 1, 0, CMD_LO);
    period(600, BUS_HI + 10);
    chk_all("R11 stays", 1, 1, 0, CMD_LO);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_entry();
    t_skip();
    t_ignore();
    t_recharge();
    t_exit();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule